// File: doc/BRIEF.md
# Timer Time Base with Update Control

This block is the counting core of a general-purpose timer. A kernel clock feeds a prescaler, and the prescaler's ticks advance a 16-bit up-counter. When the counter reaches the active auto-reload limit on a tick, it wraps to zero. That overflow is one of two sources of an update event. The other source is a software strobe. On an update event the prescaler and auto-reload shadow registers take their pending values, and the update flag may be set.

Software drives the block through plain control pins. A control write strobe loads every control bit at once. Separate write strobes load the auto-reload and prescaler values. Single-cycle pulses request an update or clear the flag. A set of qualifiers changes what an update event does:

- one control bit suppresses updates entirely;
- another limits the flag to counter overflows only;
- a one-shot bit makes the block drop its own run bit at the next update;
- a buffering bit decides whether a limit write takes effect at once or waits for the next update.

The block also derives a sampling-clock enable from a divider code. It presents the count on a 32-bit readback whose top bit can mirror the flag. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure; every pin is plain control or status.

Top module: `tbase_timer`

## Requirements
- R1: After reset the count is 0, the flag, interrupt and run bit are 0, the active limit reads all ones (0xFFFF), and the prescaler divides by 1.
- R2: The counter advances only while the run bit is 1. While the run bit is 0, the count holds its value.
- R3: On a prescaler tick with the count equal to the active limit, the count wraps to 0 on that same clock edge, and the flag is set if updates are allowed.
- R4: The prescaler divides the kernel clock by its active value plus one. A prescaler write becomes active only at the next update event.
- R5: With update suppression at 1, neither overflow nor the software strobe sets the flag or reloads the shadows. The software strobe still clears the count and the prescaler.
- R6: With the overflow-only bit at 0, the software strobe sets the flag. With it at 1, only an overflow sets the flag, while the software strobe still reloads the shadows.
- R7: With the one-shot bit at 1, any update event clears the run bit, and the count then stays where it wrapped.
- R8: With the buffering bit at 0, a limit write changes the active limit on the next edge. With it at 1, the write waits in a pending register until an update event.
- R9: The sampling enable pulses on every kernel cycle for divider code 0, on every second cycle for code 1, on every fourth cycle for code 2, and on every cycle for code 3.
- R10: The flag is sticky until a clear pulse; a set on the same edge wins over the clear. The interrupt output equals the flag AND the interrupt-enable bit.
- R11: The readback carries the count in bits 15:0 and zeros in bits 30:16. Bit 31 is the flag when the mirror bit is 1, and 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Loads all control bits below |
| ctl_run | input | 1 | Run (counter enable) value |
| ctl_upd_off | input | 1 | Update suppression value |
| ctl_ovf_only | input | 1 | Flag from overflow only |
| ctl_single | input | 1 | One-shot mode value |
| ctl_arr_buf | input | 1 | Limit buffering value |
| ctl_div | input | 2 | Sampling-clock divider code |
| ctl_mirror | input | 1 | Mirror flag into readback bit 31 |
| ctl_irq_en | input | 1 | Update interrupt enable |
| arr_we | input | 1 | Limit write strobe |
| arr_wdata | input | 16 | Limit write value |
| psc_we | input | 1 | Prescaler write strobe |
| psc_wdata | input | 16 | Prescaler write value |
| sw_update | input | 1 | Software update request pulse |
| flag_clr | input | 1 | Flag clear pulse |
| run | output | 1 | Current run bit |
| flag | output | 1 | Update flag |
| irq | output | 1 | Update interrupt |
| cnt_view | output | 32 | Count readback with optional mirrored flag |
| arr_now | output | 16 | Active limit |
| samp_en | output | 1 | Sampling-clock enable |

## Verification
The bench runs the counter with the prescaler at 1 and then at 3. Comparing the two shows whether a prescaler write is held back until an update or applied at once. The software strobe is tried under all three qualifier settings:

- free updates, which both reloads the shadows and sets the flag;
- suppressed updates, which only clears the count;
- overflow-only, which reloads the shadows without setting the flag.

Each of these outcomes can only be produced by its own gating. Limit writes are made both buffered and direct, and a one-shot run is let past its overflow to show that the count then halts. Each divider code is counted over sixteen cycles, so that every pulse rate can be told apart from the others.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  typedef struct packed {
    logic       run;
    logic       upd_off;
    logic       ovf_only;
    logic       single;
    logic       arr_buf;
    logic [1:0] div;
    logic       mirror;
    logic       irq_en;
  } ctl_t;
endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reinit,
  input  logic             upd,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wdata,
  output logic             tick
);
  logic [PSC_W-1:0] psc_pre, psc_act, pcnt;

  assign tick = run && !reinit && (pcnt == psc_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_pre <= '0;
      psc_act <= '0;
      pcnt    <= '0;
    end else begin
      if (psc_we) psc_pre <= psc_wdata;
      if (upd)    psc_act <= psc_pre;
      if (reinit)    pcnt <= '0;
      else if (tick) pcnt <= '0;
      else if (run)  pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/tbt_counter.sv
module tbt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reinit,
  input  logic             upd,
  input  logic             arr_buf,
  input  logic             arr_we,
  input  logic [CNT_W-1:0] arr_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] arr_act,
  output logic             ovf
);
  logic [CNT_W-1:0] arr_pre;
  logic             at_limit;

  assign at_limit = (cnt == arr_act);
  assign ovf      = tick && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (reinit) cnt <= '0;
    else if (tick)   cnt <= at_limit ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_pre <= '1;
      arr_act <= '1;
    end else begin
      if (arr_we) arr_pre <= arr_wdata;
      if (arr_we && !arr_buf) arr_act <= arr_wdata;
      else if (upd)           arr_act <= arr_pre;
    end
  end
endmodule

// File: rtl/tbt_sampclk.sv
module tbt_sampclk #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             samp_en
);
  logic [1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else        dcnt <= dcnt + 1'b1;
  end

  always_comb begin
    case (div)
      2'd1:    samp_en = dcnt[0];
      2'd2:    samp_en = (dcnt == 2'd3);
      default: samp_en = 1'b1;
    endcase
  end
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic             ctl_upd_off,
  input  logic             ctl_ovf_only,
  input  logic             ctl_single,
  input  logic             ctl_arr_buf,
  input  logic [DIV_W-1:0] ctl_div,
  input  logic             ctl_mirror,
  input  logic             ctl_irq_en,
  input  logic             arr_we,
  input  logic [CNT_W-1:0] arr_wdata,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             sw_update,
  input  logic             flag_clr,
  output logic             run,
  output logic             flag,
  output logic             irq,
  output logic [31:0]      cnt_view,
  output logic [CNT_W-1:0] arr_now,
  output logic             samp_en
);
  import tbt_pkg::*;
  localparam int VIEW_W = 32;
  localparam int PAD_W  = VIEW_W - 1 - CNT_W;

  ctl_t             ctl_q, ctl_in;
  logic             tick, ovf, upd, flag_set;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    ctl_in          = '0;
    ctl_in.run      = ctl_run;
    ctl_in.upd_off  = ctl_upd_off;
    ctl_in.ovf_only = ctl_ovf_only;
    ctl_in.single   = ctl_single;
    ctl_in.arr_buf  = ctl_arr_buf;
    ctl_in.div      = ctl_div;
    ctl_in.mirror   = ctl_mirror;
    ctl_in.irq_en   = ctl_irq_en;
  end

  assign upd      = (ovf || sw_update) && !ctl_q.upd_off;
  assign flag_set = !ctl_q.upd_off && (ovf || (sw_update && !ctl_q.ovf_only));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ctl_q     <= '0;
    else if (ctl_we)                 ctl_q     <= ctl_in;
    else if (ctl_q.single && upd)    ctl_q.run <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (flag_set) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  tbt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .reinit(sw_update), .upd(upd),
    .psc_we(psc_we), .psc_wdata(psc_wdata), .tick(tick)
  );

  tbt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reinit(sw_update), .upd(upd),
    .arr_buf(ctl_q.arr_buf), .arr_we(arr_we), .arr_wdata(arr_wdata),
    .cnt(cnt), .arr_act(arr_now), .ovf(ovf)
  );

  tbt_sampclk #(.DIV_W(DIV_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .div(ctl_q.div), .samp_en(samp_en)
  );

  assign run      = ctl_q.run;
  assign irq      = flag && ctl_q.irq_en;
  assign cnt_view = {ctl_q.mirror && flag, {PAD_W{1'b0}}, cnt};
endmodule

// File: rtl/tbt_chk.sv
module tbt_chk (
  input logic           clk,
  input logic           rst_n,
  input tbt_pkg::ctl_t  ctl,
  input logic           ctl_we,
  input logic           sw_update,
  input logic           flag_clr,
  input logic           flag,
  input logic [31:0]    cnt_view
);
  // R2: a stopped counter holds
  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !sw_update) |=> $stable(cnt_view[15:0]));

  // R5: software strobe always clears the count
  assert_strobe_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_update |=> (cnt_view[15:0] == 16'd0));

  // R5: no flag while updates are suppressed
  assert_no_flag_suppressed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.upd_off && !flag) |=> !flag);

  // R7: one-shot stops on a software update
  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.single && ctl.run && sw_update && !ctl.upd_off && !ctl_we) |=> !ctl.run);

  // R10: flag is sticky without a clear
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  // R11: bit 31 is zero when mirroring is off
  assert_mirror_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.mirror |-> !cnt_view[31]);
endmodule

bind tbase_timer tbt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .ctl_we(ctl_we), .sw_update(sw_update),
  .flag_clr(flag_clr), .flag(flag), .cnt_view(cnt_view)
);

// File: tb/tb_tbase_timer.sv
module tb_tbase_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, ctl_run = 0, ctl_upd_off = 0, ctl_ovf_only = 0, ctl_single = 0;
  logic ctl_arr_buf = 0, ctl_mirror = 0, ctl_irq_en = 0;
  logic [1:0] ctl_div = 0;
  logic arr_we = 0, psc_we = 0, sw_update = 0, flag_clr = 0;
  logic [15:0] arr_wdata = 0, psc_wdata = 0;
  logic run, flag, irq, samp_en;
  logic [31:0] cnt_view;
  logic [15:0] arr_now;
  int checks = 0, errors = 0;
  bit done = 0;

  tbase_timer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic r);
    ctl_run = r; ctl_we = 1; @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_arr(input logic [15:0] v);
    arr_wdata = v; arr_we = 1; @(negedge clk); arr_we = 0;
  endtask

  task automatic wr_psc(input logic [15:0] v);
    psc_wdata = v; psc_we = 1; @(negedge clk); psc_we = 0;
  endtask

  task automatic pulse_upd();
    sw_update = 1; @(negedge clk); sw_update = 0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", cnt_view, 0);
    chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 run", run, 0);
    chk("R1 limit", arr_now, 16'hFFFF);
  endtask

  task automatic t_enable();
    wr_arr(16'd100);
    chk("R8 direct limit write", arr_now, 100);
    wr_ctl(1);
    chk("R2 start count", cnt_view[15:0], 0);
    step(3);
    chk("R2 counting", cnt_view[15:0], 3);
    wr_ctl(0);
    step(3);
    chk("R2 hold when stopped", cnt_view[15:0], 4);
    pulse_upd();
    pulse_clr();
  endtask

  task automatic t_overflow();
    wr_arr(16'd4);
    ctl_irq_en = 1; ctl_mirror = 1;
    wr_ctl(1);
    step(4);
    chk("R3 before wrap", cnt_view[15:0], 4);
    chk("R3 no flag yet", flag, 0);
    step(1);
    chk("R3 wrapped", cnt_view[15:0], 0);
    chk("R3 flag set", flag, 1);
    chk("R10 irq follows flag", irq, 1);
    chk("R11 mirrored bit", cnt_view[31], 1);
    step(3);
    chk("R10 flag sticky", flag, 1);
    pulse_clr();
    chk("R10 flag cleared", flag, 0);
    chk("R10 irq cleared", irq, 0);
    wr_ctl(0);
  endtask

  task automatic t_psc();
    wr_arr(16'd100);
    pulse_upd();
    pulse_clr();
    wr_psc(16'd2);
    wr_ctl(1);
    step(2);
    chk("R4 psc not yet active", cnt_view[15:0], 2);
    pulse_upd();
    chk("R4 reinit", cnt_view[15:0], 0);
    step(2);
    chk("R4 divided hold", cnt_view[15:0], 0);
    step(1);
    chk("R4 divided tick", cnt_view[15:0], 1);
    step(3);
    chk("R4 second tick", cnt_view[15:0], 2);
    wr_ctl(0);
    wr_psc(16'd0);
    pulse_upd();
    pulse_clr();
  endtask

  task automatic t_upd_off();
    ctl_arr_buf = 1; ctl_upd_off = 1;
    wr_ctl(0);
    wr_arr(16'd3);
    chk("R8 buffered write waits", arr_now, 100);
    pulse_upd();
    chk("R5 strobe clears count", cnt_view[15:0], 0);
    chk("R5 no flag", flag, 0);
    chk("R5 shadow kept", arr_now, 100);
    ctl_upd_off = 0;
    wr_ctl(0);
    pulse_upd();
    chk("R8 loaded at update", arr_now, 3);
    chk("R6 strobe sets flag", flag, 1);
    pulse_clr();
    ctl_upd_off = 1;
    wr_ctl(1);
    step(4);
    chk("R5 wrap while suppressed", cnt_view[15:0], 0);
    chk("R5 overflow no flag", flag, 0);
    ctl_upd_off = 0;
    wr_ctl(0);
  endtask

  task automatic t_urs();
    ctl_ovf_only = 1;
    wr_ctl(0);
    wr_arr(16'd6);
    pulse_upd();
    chk("R6 silent reload", arr_now, 6);
    chk("R6 strobe no flag", flag, 0);
    wr_ctl(1);
    step(7);
    chk("R6 overflow sets flag", flag, 1);
    wr_ctl(0);
    ctl_ovf_only = 0;
    pulse_upd();
    pulse_clr();
  endtask

  task automatic t_opm();
    ctl_single = 1;
    wr_ctl(1);
    step(6);
    chk("R7 running", run, 1);
    step(1);
    chk("R7 stopped", run, 0);
    chk("R7 wrapped", cnt_view[15:0], 0);
    step(3);
    chk("R7 stays halted", cnt_view[15:0], 0);
    ctl_single = 0;
  endtask

  task automatic t_mirror();
    chk("R11 flag set", flag, 1);
    ctl_mirror = 0;
    wr_ctl(0);
    chk("R11 bit31 off", cnt_view[31], 0);
    ctl_irq_en = 0;
    wr_ctl(0);
    chk("R10 irq masked", irq, 0);
    ctl_mirror = 1;
    wr_ctl(0);
    chk("R11 readback", cnt_view, 32'h8000_0000);
  endtask

  task automatic t_div();
    int exp[4] = '{16, 8, 4, 16};
    for (int c = 0; c < 4; c++) begin
      int n = 0;
      ctl_div = 2'(c);
      wr_ctl(0);
      for (int k = 0; k < 16; k++) begin
        if (samp_en) n++;
        step(1);
      end
      chk($sformatf("R9 div code %0d", c), n, exp[c]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_enable();
    t_overflow();
    t_psc();
    t_upd_off();
    t_urs();
    t_opm();
    t_mirror();
    t_div();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule